// File: doc/BRIEF.md
# Auto-Reload Wakeup Down-Counter

This block is the periodic wakeup timer of a real-time clock. Software programs a 16-bit reload value and a 3-bit count-clock code, then sets the run bit. The counter then counts down from the reload value at the chosen rate. Each time it steps at zero it raises a sticky wakeup flag and loads itself again, so wakeups repeat with no further software action. The count rate is either the kernel clock divided by a power of two, or a one-pulse-per-second tick from the calendar prescaler. One tick encoding adds 2^16 to every count, which roughly doubles the longest period.

Register decoding and write protection are left to the surrounding logic. Configuration and control reach the block as plain write strobes. A controller with four states sequences the timer. OFF is idle, and only OFF opens configuration writes. LOAD is a single cycle that copies the reload value into the counter. COUNT is the running state. HALT is a single settling cycle after the run bit is cleared.

The transitions are these:
- arm: OFF or HALT goes to LOAD on a control write with run=1.
- start: LOAD goes to COUNT.
- stop: LOAD or COUNT goes to HALT on a control write with run=0.
- settle: HALT goes to OFF.

Top module: `wkup_timer`

## Requirements
- R1: With cfg_sel codes 000, 001, 010 and 011, the counter steps once every 16, 8, 4 and 2 kernel-clock cycles of COUNT. The first wakeup flag rises 2 + D*(reload+1) clock edges after the arming control write edge, counting that edge, where D is the divisor.
- R2: A step taken while the count is zero sets wake_flag and reloads the counter. Later wakeups therefore repeat every D*(reload+1) cycles without re-arming.
- R3: With cfg_sel codes 100 and 101, the counter steps only on cycles of COUNT in which tick_1hz is high. The period is reload+1 ticks.
- R4: With cfg_sel codes 110 and 111, the count loaded into the counter is reload + 65536. The period is reload + 65537 ticks.
- R5: wr_ok is 1 out of reset. After a control write with run=0, wr_ok is 0 for one cycle (HALT) and is 1 after the second edge (OFF).
- R6: After a control write with run=1, wr_ok is 0 from the next edge onward.
- R7: A configuration write (cfg_we) made while wr_ok is 0 changes neither the reload value nor cfg_sel.
- R8: Re-arming always starts a full period from the reload value, whatever count was left when the timer was stopped.
- R9: wake_flag stays 1 until a flag_clr strobe. If a wakeup and flag_clr occur in the same cycle, the flag stays 1.
- R10: wake_irq equals wake_flag gated by the interrupt-enable bit, which every control write loads from ctl_irq_en.
- R11: Stopping the timer leaves wake_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle second tick from the calendar prescaler |
| cfg_we | input | 1 | Configuration write strobe (reload and clock code) |
| cfg_reload | input | 16 | Reload value |
| cfg_sel | input | 3 | Count-clock code |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit carried by a control write |
| ctl_irq_en | input | 1 | Interrupt-enable bit carried by a control write |
| flag_clr | input | 1 | Wakeup flag clear strobe |
| wr_ok | output | 1 | Configuration writes are currently accepted |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | Wakeup interrupt request |

## Verification
The hardest case to reach from the ports is a wakeup and a flag clear landing on the same edge. The bench forces it by running in tick mode with a reload of zero and a tick on every cycle. In that setup the counter wakes on every COUNT edge, so any flag_clr pulse collides with a set. The extended tick mode is covered the same way: a tick on every cycle brings its 65,537-tick period within reach. Ignored configuration writes and the restart after a mid-count stop are checked through the period measured on the next run.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;

    // Sequencer states of the wakeup timer
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HALT  = 2'd1,
        ST_LOAD  = 2'd2,
        ST_COUNT = 2'd3
    } wk_state_e;

    // Top code bit picks the second tick; both top bits set add the extension
    function automatic logic sel_is_tick(input logic [2:0] code);
        return code[2];
    endfunction

    function automatic logic sel_is_ext(input logic [2:0] code);
        return code[2] & code[1];
    endfunction

endpackage

// File: rtl/wkup_ctrl.sv
`timescale 1ns/1ps
module wkup_ctrl
    import wkup_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_run,
    input  logic             ctl_irq_en,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             wr_ok,
    output logic             load_o,
    output logic             run_o,
    output logic [CNT_W-1:0] reload_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             irq_en_q
);

    wk_state_e state_q, state_d;

    logic arm_req, stop_req;
    assign arm_req  = ctl_we & ctl_run;
    assign stop_req = ctl_we & ~ctl_run;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, start, stop, settle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (arm_req) state_d = ST_LOAD;
            ST_HALT:  state_d = arm_req ? ST_LOAD : ST_OFF;
            ST_LOAD:  state_d = stop_req ? ST_HALT : ST_COUNT;
            ST_COUNT: if (stop_req) state_d = ST_HALT;
            default:  state_d = ST_OFF;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        wr_ok  = 1'b0;
        load_o = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            ST_OFF:   wr_ok  = 1'b1;
            ST_LOAD:  load_o = 1'b1;
            ST_COUNT: run_o  = 1'b1;
            default:  ;
        endcase
    end

    // Configuration and interrupt-enable holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            sel_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (cfg_we && wr_ok) begin
                reload_q <= cfg_reload;
                sel_q    <= cfg_sel;
            end
            if (ctl_we) begin
                irq_en_q <= ctl_irq_en;
            end
        end
    end

    // R6
    arm_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> !wr_ok);

    // R5
    settle_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !ctl_we) |=> wr_ok);

    // R7
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wr_ok) |=> ($stable(reload_q) && $stable(sel_q)));

endmodule

// File: rtl/wkup_stepgen.sv
`timescale 1ns/1ps
module wkup_stepgen #(
    parameter int DIV_STAGES = 4,
    parameter int SEL_W      = $clog2(DIV_STAGES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick,
    output logic             step
);

    localparam int CODE_W = SEL_W - 1;

    logic [DIV_STAGES-1:0] pre_q;
    logic [DIV_STAGES-1:0] tap;
    logic [CODE_W-1:0]     tap_idx;

    // Free prescaler, cleared on every (re)start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // tap[k] fires once every 2^(k+1) counts
    for (genvar k = 0; k < DIV_STAGES; k++) begin : g_tap
        assign tap[k] = &pre_q[k:0];
    end

    // Code 0 selects the deepest divider
    assign tap_idx = CODE_W'(DIV_STAGES - 1) - sel[CODE_W-1:0];
    assign step    = run & (sel[SEL_W-1] ? tick : tap[tap_idx]);

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel[SEL_W-1] && !tick) |-> !step);

    // R1
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !step);

endmodule

// File: rtl/wkup_counter.sv
`timescale 1ns/1ps
module wkup_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             ext,
    input  logic [CNT_W-1:0] reload,
    output logic             zero_hit
);

    localparam int FULL_W = CNT_W + 1;

    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] start_val;

    assign start_val = {ext, reload};
    assign zero_hit  = step & (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || zero_hit) begin
            cnt_q <= start_val;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && !load) |=> (cnt_q == {$past(ext), $past(reload)}));

    // R8
    start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == {$past(ext), $past(reload)}));

    // R3
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/wkup_flag.sv
`timescale 1ns/1ps
module wkup_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag_o,
    output logic irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set) begin
            flag_o <= 1'b1;
        end else if (clr) begin
            flag_o <= 1'b0;
        end
    end

    assign irq_o = flag_o & ie;

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_o);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ie);

endmodule

// File: rtl/wkup_timer.sv
`timescale 1ns/1ps
module wkup_timer
    import wkup_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DIV_STAGES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_1hz,
    input  logic                          cfg_we,
    input  logic [CNT_W-1:0]              cfg_reload,
    input  logic [$clog2(DIV_STAGES):0]   cfg_sel,
    input  logic                          ctl_we,
    input  logic                          ctl_run,
    input  logic                          ctl_irq_en,
    input  logic                          flag_clr,
    output logic                          wr_ok,
    output logic                          wake_flag,
    output logic                          wake_irq
);

    localparam int SEL_W = $clog2(DIV_STAGES) + 1;

    logic             load, run, step, zero_hit, irq_en;
    logic [CNT_W-1:0] reload_q;
    logic [SEL_W-1:0] sel_q;

    wkup_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_run    (ctl_run),
        .ctl_irq_en (ctl_irq_en),
        .cfg_we     (cfg_we),
        .cfg_reload (cfg_reload),
        .cfg_sel    (cfg_sel),
        .wr_ok      (wr_ok),
        .load_o     (load),
        .run_o      (run),
        .reload_q   (reload_q),
        .sel_q      (sel_q),
        .irq_en_q   (irq_en)
    );

    wkup_stepgen #(.DIV_STAGES(DIV_STAGES), .SEL_W(SEL_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load),
        .sel     (sel_q),
        .tick    (tick_1hz),
        .step    (step)
    );

    wkup_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .ext      (sel_q[SEL_W-1] & sel_q[SEL_W-2]),
        .reload   (reload_q),
        .zero_hit (zero_hit)
    );

    wkup_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (zero_hit),
        .clr    (flag_clr),
        .ie     (irq_en),
        .flag_o (wake_flag),
        .irq_o  (wake_irq)
    );

    // R11
    stop_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_run && !flag_clr && wake_flag) |=> wake_flag);

endmodule

// File: tb/wkup_timer_tb.sv
`timescale 1ns/1ps
module wkup_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_reload = '0;
    logic [2:0]  cfg_sel = '0;
    logic        ctl_we = 1'b0;
    logic        ctl_run = 1'b0;
    logic        ctl_irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        wr_ok, wake_flag, wake_irq;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    wkup_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .cfg_we(cfg_we), .cfg_reload(cfg_reload), .cfg_sel(cfg_sel),
        .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_irq_en(ctl_irq_en),
        .flag_clr(flag_clr), .wr_ok(wr_ok), .wake_flag(wake_flag),
        .wake_irq(wake_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: 0 off, 1 halt, 2 load, 3 count
    int m_state, m_sub, m_cnt, m_reload, m_sel;
    bit m_flag, m_ie, m_wr, m_step, m_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_sub = 0; m_cnt = 0; m_reload = 0; m_sel = 0;
            m_flag = 0; m_ie = 0;
        end else begin
            m_wr = (m_state == 0);
            m_step = 0;
            m_set = 0;
            if (m_state == 3) begin
                if (m_sel >= 4) m_step = tick_1hz;
                else begin
                    m_sub = m_sub + 1;
                    m_step = ((m_sub % (16 >> m_sel)) == 0);
                end
            end
            if (m_state == 2) begin
                m_cnt = m_reload + ((m_sel >= 6) ? 65536 : 0);
                m_sub = 0;
            end else if (m_step) begin
                if (m_cnt == 0) begin
                    m_set = 1;
                    m_cnt = m_reload + ((m_sel >= 6) ? 65536 : 0);
                end else m_cnt = m_cnt - 1;
            end
            if (m_set) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (cfg_we && m_wr) begin
                m_reload = int'(cfg_reload);
                m_sel = int'(cfg_sel);
            end
            if (ctl_we) m_ie = ctl_irq_en;
            case (m_state)
                0: if (ctl_we && ctl_run) m_state = 2;
                1: m_state = (ctl_we && ctl_run) ? 2 : 0;
                2: m_state = (ctl_we && !ctl_run) ? 1 : 3;
                default: if (ctl_we && !ctl_run) m_state = 1;
            endcase
        end
    end

    // Every-cycle comparison against the reference
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmp_on) begin
                chk("R5 R6 wr_ok vs model", wr_ok, int'(m_state == 0));
                chk("R2 wake_flag vs model", wake_flag, int'(m_flag));
                chk("R10 wake_irq vs model", wake_irq, int'(m_flag && m_ie));
            end
        end
    end

    // Second-tick source
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (tick_mode == 1) tick_1hz = 1'b1;
            else if (tick_mode == 2) begin
                ph = (ph + 1) % 7;
                tick_1hz = (ph == 0);
            end else tick_1hz = 1'b0;
        end
    end

    task automatic edges(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic set_cfg(input int rl, input int sel);
        cfg_we = 1'b1; cfg_reload = 16'(rl); cfg_sel = 3'(sel);
        edges(1);
        cfg_we = 1'b0;
    endtask

    task automatic ctl(input bit run, input bit ie);
        ctl_we = 1'b1; ctl_run = run; ctl_irq_en = ie;
        edges(1);
        ctl_we = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
    endtask

    // Counts edges until wake_flag is seen high
    task automatic time_flag(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            ctl_we = 1'b0; cfg_we = 1'b0; flag_clr = 1'b0;
            if (wake_flag) break;
        end
    endtask

    task automatic enable_measure(input int exp, input bit ie, input string tag, input int limit);
        int n;
        ctl(1'b1, ie);
        chk("R6 wr_ok low after arming", wr_ok, 0);
        time_flag(limit, n);
        chk(tag, n + 1, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        chk("R5 reset wr_ok", wr_ok, 1);
        chk("R9 reset wake_flag", wake_flag, 0);
        chk("R10 reset wake_irq", wake_irq, 0);

        // Divide-by-16, reload 3
        set_cfg(3, 0);
        enable_measure(66, 1'b0, "R1 first period div16", 200);
        flag_clr = 1'b1;
        time_flag(200, n);
        chk("R2 auto-reload period", n, 64);
        chk("R10 irq masked", wake_irq, 0);
        ctl(1'b1, 1'b1);
        chk("R10 irq follows flag", wake_irq, 1);
        set_cfg(0, 3);
        ctl(1'b0, 1'b1);
        chk("R5 wr_ok low in settle cycle", wr_ok, 0);
        chk("R11 flag kept on stop", wake_flag, 1);
        edges(1);
        chk("R5 wr_ok back after stop", wr_ok, 1);
        clr_flag();
        chk("R9 flag cleared by strobe", wake_flag, 0);
        enable_measure(66, 1'b0, "R7 locked write ignored", 200);

        // Stop mid-count, re-arm
        clr_flag();
        edges(30);
        ctl(1'b0, 1'b0);
        edges(2);
        enable_measure(66, 1'b0, "R8 restart from reload", 200);

        // Other dividers, reload 5
        for (int s = 1; s < 4; s++) begin
            ctl(1'b0, 1'b0);
            edges(2);
            clr_flag();
            set_cfg(5, s);
            enable_measure(2 + (16 >> s) * 6, 1'b0, "R1 divider period", 200);
        end

        // Tick mode, code 101
        ctl(1'b0, 1'b0);
        edges(2);
        clr_flag();
        tick_mode = 1;
        set_cfg(2, 5);
        enable_measure(5, 1'b0, "R3 tick period", 100);

        // Sparse ticks, code 100
        ctl(1'b0, 1'b0);
        edges(2);
        clr_flag();
        tick_mode = 2;
        set_cfg(4, 4);
        ctl(1'b1, 1'b0);
        edges(300);
        chk("R3 sparse tick wakeup", wake_flag, 1);

        // Wakeup and clear on the same edge
        ctl(1'b0, 1'b0);
        edges(2);
        clr_flag();
        tick_mode = 1;
        set_cfg(0, 4);
        ctl(1'b1, 1'b0);
        edges(3);
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
        chk("R9 set wins over clear", wake_flag, 1);
        tick_mode = 0;
        edges(2);
        clr_flag();
        chk("R9 clear without wakeup", wake_flag, 0);
        edges(5);
        chk("R9 stays clear", wake_flag, 0);

        // Extended tick mode, code 110
        ctl(1'b0, 1'b0);
        edges(2);
        clr_flag();
        tick_mode = 1;
        set_cfg(0, 6);
        enable_measure(65539, 1'b0, "R4 extended period", 70000);

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule